// File: doc/BRIEF.md
# PWM Break Input Conditioning Unit

This unit gathers fault requests for a motor-control PWM timer and turns them into one master output enable that shuts the power stage down. There are three break channels. Two are primary channels. Each primary channel merges one external pin with a group of comparator outputs. Each has its own enable bit, polarity select and digital glitch filter, and each can also be tripped by a software event. The third channel is internal only. It takes system fault flags (clock failure, supply monitor, memory parity, processor lockup and selected comparators), is always armed and reaches the output without a filter or a clock edge.

Software reaches the unit through a small register port. The port has one write channel (strobe, address, data) and one combinational read channel. Through it, software programs the channels, sets the master enable, fires software breaks and clears the sticky per-channel cause flags. Configuration writes are staged for one cycle before they act. The master enable drops combinationally when a break occurs. Its register readback passes through a two-flop resynchronizer.

Top module: `brk_cond_top`

## Requirements
- R1: After reset, `pwm_oe` is 0, `brk_flags` is 0 and the configuration register (address 0) reads 0, so both primary channels are disabled.
- R2: A primary channel's raw request is the OR of its pin and all of its comparator inputs. The internal channel requests a break when any bit of `sys_flt` is 1.
- R3: While a primary channel's enable bit is 0, its pin and comparator inputs have no effect on `pwm_oe` or `brk_flags`.
- R4: The polarity bit selects the asserted level of the OR-ed raw request: 1 means high, 0 means low. The inactive level never trips the channel.
- R5: The configuration register at address 0 holds channel A in bits [5:0] and channel B in bits [11:6]. Within each 6-bit group, bit 0 is enable, bit 1 is polarity and bits [5:2] are the filter select. A write acts, and reads back, one clock after the clock edge that captures it. A read in between returns the old value.
- R6: A filter select of 0 raises the channel request on the first sampled asserted clock. A value N>0 requires 2·N consecutive sampled asserted clocks. A shorter pulse causes no break.
- R7: The internal channel is unfiltered: `pwm_oe` falls in the same cycle that a `sys_flt` bit rises, with no clock edge in between.
- R8: Writing 1 to bit 0 (channel A) or bit 1 (channel B) of address 2 forces a break on that channel even when it is disabled.
- R9: A break drives `pwm_oe` to 0 at once and keeps it 0. Only a later write of 1 to bit 0 of address 1 sets it again, and that write is ignored while any break request is active.
- R10: Reading address 1 returns the output enable through a two-stage resynchronizer. After `pwm_oe` rises, bit 0 reads 1 only two clock edges later.
- R11: `brk_flags` (also at address 3) holds sticky cause bits: bit 0 for channel A, bit 1 for channel B and bit 2 for the internal channel. Writing 1 to a bit of address 3 clears it. A new break in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| brk_pin | input | NUM_PRI (2) | External break pin per primary channel |
| brk_cmp | input | NUM_PRI x N_CMP (2x3) | Comparator outputs per primary channel |
| sys_flt | input | N_SYS (5) | Internal-channel fault flags |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 12 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 12 | Register read data (combinational) |
| pwm_oe | output | 1 | Master output enable to the PWM stage |
| brk_flags | output | 3 | Sticky break cause flags |

## Verification
Suppose the filter counter were wrong. It would show at `pwm_oe` on the sampled clock where a pulse of exactly 2·N or 2·N-1 cycles ends: the output either falls one pulse too early or stays high. So the bench sweeps pulse lengths around each threshold. A wrongly staged configuration register would show as a readback mismatch in the cycle right after the write. A bad latch on the master enable would show up a few cycles after the fault is released, when `pwm_oe` rises again without a software write. A lost cause flag would show in `brk_flags` one edge after the break.

// File: rtl/brk_pkg.sv
package brk_pkg;

    localparam int NUM_PRI = 2;
    localparam int NUM_ALL = NUM_PRI + 1;
    localparam int FILT_W  = 4;
    localparam int CNT_W   = FILT_W + 1;
    localparam int REG_AW  = 2;

    typedef enum logic [REG_AW-1:0] {
        ADDR_CFG  = 2'd0,
        ADDR_OE   = 2'd1,
        ADDR_EVT  = 2'd2,
        ADDR_STAT = 2'd3
    } reg_addr_e;

    typedef struct packed {
        logic [FILT_W-1:0] filt;
        logic              pol;
        logic              en;
    } chan_cfg_t;

    typedef chan_cfg_t [NUM_PRI-1:0] cfg_arr_t;

    localparam int REG_DW = $bits(cfg_arr_t);

    function automatic logic level_hit(input logic raw, input logic pol);
        return raw == pol;
    endfunction

    function automatic logic [CNT_W-1:0] filt_thr(input logic [FILT_W-1:0] n);
        return (n == '0) ? CNT_W'(1) : {n, 1'b0};
    endfunction

endpackage

// File: rtl/brk_filter.sv
module brk_filter
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              sample_in,
    input  logic [FILT_W-1:0] filt_sel,
    output logic              req
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cnt_nxt;

    always_comb begin
        cnt_nxt = (cnt == CNT_MAX) ? cnt : cnt + CNT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            req <= 1'b0;
        end else if (!sample_in) begin
            cnt <= '0;
            req <= 1'b0;
        end else begin
            cnt <= cnt_nxt;
            req <= (cnt_nxt >= filt_thr(filt_sel));
        end
    end

    // R6
    req_needs_input_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(req) |-> $past(sample_in));

    // R6
    drop_on_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !sample_in |=> !req);

endmodule

// File: rtl/brk_regs.sv
module brk_regs
    import brk_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [REG_AW-1:0] wr_addr,
    input  logic [REG_DW-1:0] wr_data,
    input  logic [NUM_ALL-1:0] fire,
    output cfg_arr_t          cfg,
    output logic [NUM_PRI-1:0] sw_pulse,
    output logic [NUM_ALL-1:0] stat,
    output logic              oe_set,
    output logic              oe_clr
);
    logic     cfg_wr, evt_wr, stat_wr, oe_wr;
    cfg_arr_t cfg_pend;
    logic     pend_vld;
    logic [NUM_ALL-1:0] stat_clr;

    always_comb begin
        cfg_wr   = wr_en && (reg_addr_e'(wr_addr) == ADDR_CFG);
        oe_wr    = wr_en && (reg_addr_e'(wr_addr) == ADDR_OE);
        evt_wr   = wr_en && (reg_addr_e'(wr_addr) == ADDR_EVT);
        stat_wr  = wr_en && (reg_addr_e'(wr_addr) == ADDR_STAT);
        stat_clr = stat_wr ? wr_data[NUM_ALL-1:0] : '0;
        oe_set   = oe_wr && wr_data[0];
        oe_clr   = oe_wr && !wr_data[0];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_pend <= '0;
            pend_vld <= 1'b0;
            cfg      <= '0;
            sw_pulse <= '0;
            stat     <= '0;
        end else begin
            pend_vld <= cfg_wr;
            if (cfg_wr)
                cfg_pend <= cfg_arr_t'(wr_data);
            if (pend_vld)
                cfg <= cfg_pend;
            sw_pulse <= evt_wr ? wr_data[NUM_PRI-1:0] : '0;
            stat     <= (stat & ~stat_clr) | fire;
        end
    end

    // R1
    cfg_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (cfg == '0 && stat == '0));

    // R5
    cfg_delay_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cfg) |-> $past(cfg_wr, 2));

    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (($past(stat) & ~stat) != '0) |-> $past(stat_wr));

    // R11
    flag_set_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(fire) != '0) |-> ((stat & $past(fire)) == $past(fire)));

endmodule

// File: rtl/brk_oe.sv
module brk_oe (
    input  logic clk,
    input  logic rst,
    input  logic any_brk,
    input  logic set_req,
    input  logic clr_req,
    output logic pwm_oe,
    output logic oe_rb
);
    logic moe_q;
    logic sync1;

    always_ff @(posedge clk) begin
        if (rst)
            moe_q <= 1'b0;
        else if (any_brk || clr_req)
            moe_q <= 1'b0;
        else if (set_req)
            moe_q <= 1'b1;
    end

    assign pwm_oe = moe_q & ~any_brk;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync1 <= 1'b0;
            oe_rb <= 1'b0;
        end else begin
            sync1 <= pwm_oe;
            oe_rb <= sync1;
        end
    end

    // R1
    oe_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !moe_q);

    // R9
    brk_clears_chk: assert property (@(posedge clk) disable iff (rst)
        any_brk |=> !moe_q);

    // R9
    set_by_sw_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(moe_q) |-> ($past(set_req) && !$past(any_brk)));

    // R10
    rb_lag_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(oe_rb) |-> $past(pwm_oe, 2));

endmodule

// File: rtl/brk_cond_top.sv
module brk_cond_top
    import brk_pkg::*;
#(
    parameter int N_CMP = 3,
    parameter int N_SYS = 5
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [NUM_PRI-1:0]            brk_pin,
    input  logic [NUM_PRI-1:0][N_CMP-1:0] brk_cmp,
    input  logic [N_SYS-1:0]              sys_flt,
    input  logic                          wr_en,
    input  logic [REG_AW-1:0]             wr_addr,
    input  logic [REG_DW-1:0]             wr_data,
    input  logic [REG_AW-1:0]             rd_addr,
    output logic [REG_DW-1:0]             rd_data,
    output logic                          pwm_oe,
    output logic [NUM_ALL-1:0]            brk_flags
);
    cfg_arr_t           cfg;
    logic [NUM_PRI-1:0] sw_pulse;
    logic [NUM_PRI-1:0] filt_req;
    logic [NUM_ALL-1:0] fire;
    logic [NUM_ALL-1:0] stat;
    logic               any_brk;
    logic               oe_set, oe_clr, oe_rb;

    for (genvar c = 0; c < NUM_PRI; c++) begin : g_ch
        logic raw;
        logic hit;

        assign raw = brk_pin[c] | (|brk_cmp[c]);
        assign hit = cfg[c].en & level_hit(raw, cfg[c].pol);

        brk_filter u_filt (
            .clk      (clk),
            .rst      (rst),
            .sample_in(hit),
            .filt_sel (cfg[c].filt),
            .req      (filt_req[c])
        );

        assign fire[c] = filt_req[c] | sw_pulse[c];

        // R3
        disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
            !cfg[c].en |=> !filt_req[c]);
    end

    assign fire[NUM_PRI] = |sys_flt;
    assign any_brk       = |fire;

    brk_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .fire    (fire),
        .cfg     (cfg),
        .sw_pulse(sw_pulse),
        .stat    (stat),
        .oe_set  (oe_set),
        .oe_clr  (oe_clr)
    );

    brk_oe u_oe (
        .clk    (clk),
        .rst    (rst),
        .any_brk(any_brk),
        .set_req(oe_set),
        .clr_req(oe_clr),
        .pwm_oe (pwm_oe),
        .oe_rb  (oe_rb)
    );

    assign brk_flags = stat;

    always_comb begin
        case (reg_addr_e'(rd_addr))
            ADDR_CFG:  rd_data = cfg;
            ADDR_OE:   rd_data = REG_DW'(oe_rb);
            ADDR_STAT: rd_data = REG_DW'(stat);
            default:   rd_data = '0;
        endcase
    end

    // R7
    internal_async_chk: assert property (@(posedge clk) disable iff (rst)
        (|sys_flt) |-> !pwm_oe);

    // R8
    sw_break_chk: assert property (@(posedge clk) disable iff (rst)
        (|sw_pulse) |=> (!pwm_oe && ((stat[NUM_PRI-1:0] & $past(sw_pulse)) == $past(sw_pulse))));

endmodule

// File: tb/brk_cond_top_tb_top.sv
module brk_cond_top_tb_top;

    logic            clk = 1'b0;
    logic            rst;
    logic [1:0]      brk_pin;
    logic [1:0][2:0] brk_cmp;
    logic [4:0]      sys_flt;
    logic            wr_en;
    logic [1:0]      wr_addr;
    logic [11:0]     wr_data;
    logic [1:0]      rd_addr;
    logic [11:0]     rd_data;
    logic            pwm_oe;
    logic [2:0]      brk_flags;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 0;

    always #5 clk = ~clk;

    brk_cond_top dut_i (
        .clk      (clk),
        .rst      (rst),
        .brk_pin  (brk_pin),
        .brk_cmp  (brk_cmp),
        .sys_flt  (sys_flt),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .pwm_oe   (pwm_oe),
        .brk_flags(brk_flags)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [11:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [11:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    function automatic int thr(input int n);
        return (n == 0) ? 1 : 2 * n;
    endfunction

    task automatic set_idle(input int ch, input bit pol);
        brk_cmp[ch] = '0;
        brk_pin[ch] = ~pol;
    endtask

    // one filtered pulse on a primary channel, checked for R4, R6, R11
    task automatic run_case(input int ch, input int n, input bit pol, input int src, input int len);
        logic [11:0] cw;
        bit          exp_brk;
        wr(2'd0, 12'h000);
        set_idle(0, 1'b1);
        set_idle(1, 1'b1);
        set_idle(ch, pol);
        @(negedge clk);
        cw = 12'(({n[3:0], pol, 1'b1}) << (6 * ch));
        wr(2'd0, cw);
        @(negedge clk);
        wr(2'd3, 12'h7);
        wr(2'd1, 12'h1);
        chk(pwm_oe == 1'b1, "R4 idle level", int'(pwm_oe), 1);
        if (pol) begin
            if (src == 0) brk_pin[ch] = 1'b1;
            else          brk_cmp[ch][src-1] = 1'b1;
        end else begin
            brk_pin[ch] = 1'b0;
        end
        repeat (len) @(negedge clk);
        set_idle(ch, pol);
        repeat (3) @(negedge clk);
        exp_brk = (len >= thr(n));
        chk(pwm_oe == !exp_brk, "R6 filter threshold", int'(pwm_oe), int'(!exp_brk));
        chk(brk_flags == (exp_brk ? 3'(1 << ch) : 3'd0), "R11 cause flag",
            int'(brk_flags), exp_brk ? (1 << ch) : 0);
        if (exp_brk) begin
            wr(2'd3, 12'(1 << ch));
            chk(brk_flags == 3'd0, "R11 write-one clear", int'(brk_flags), 0);
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [11:0] r;
        void'($urandom(32'd20240611));
        rst = 1'b1; brk_pin = '0; brk_cmp = '0; sys_flt = '0;
        wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(pwm_oe == 1'b0, "R1 oe after reset", int'(pwm_oe), 0);
        chk(brk_flags == 3'd0, "R1 flags after reset", int'(brk_flags), 0);
        rd(2'd0, r);
        chk(r == 12'd0, "R1 config after reset", int'(r), 0);

        // R10 set enable, readback lags two edges
        wr(2'd1, 12'h1);
        chk(pwm_oe == 1'b1, "R9 set by write", int'(pwm_oe), 1);
        rd(2'd1, r);
        chk(r == 12'd0, "R10 readback not yet", int'(r), 0);
        @(negedge clk);
        rd(2'd1, r);
        chk(r == 12'd0, "R10 readback one edge", int'(r), 0);
        @(negedge clk);
        rd(2'd1, r);
        chk(r == 12'd1, "R10 readback two edges", int'(r), 1);

        // R5 staged configuration
        wr(2'd0, 12'h003);
        rd(2'd0, r);
        chk(r == 12'd0, "R5 old value right after write", int'(r), 0);
        @(negedge clk);
        rd(2'd0, r);
        chk(r == 12'h003, "R5 new value one clock later", int'(r), 3);

        // R3 disabled channel B ignores its inputs
        brk_pin[1] = 1'b1; brk_cmp[1] = 3'b111;
        repeat (5) @(negedge clk);
        chk(pwm_oe == 1'b1, "R3 disabled channel ignored", int'(pwm_oe), 1);
        chk(brk_flags == 3'd0, "R3 no flag from disabled", int'(brk_flags), 0);
        brk_pin[1] = 1'b0; brk_cmp[1] = '0;

        // R2 comparator input on channel A, filter 0
        brk_cmp[0][1] = 1'b1;
        @(negedge clk);
        chk(pwm_oe == 1'b0, "R2 comparator trips channel", int'(pwm_oe), 0);
        @(negedge clk);
        chk(brk_flags == 3'b001, "R11 flag A set", int'(brk_flags), 1);
        brk_cmp[0][1] = 1'b0;
        repeat (4) @(negedge clk);
        chk(pwm_oe == 1'b0, "R9 stays off after release", int'(pwm_oe), 0);
        wr(2'd3, 12'h1);
        chk(brk_flags == 3'd0, "R11 clear A", int'(brk_flags), 0);

        // R7 internal channel, R9 write ignored while active
        wr(2'd1, 12'h1);
        chk(pwm_oe == 1'b1, "R9 re-enable", int'(pwm_oe), 1);
        sys_flt[3] = 1'b1;
        #1;
        chk(pwm_oe == 1'b0, "R7 unfiltered same cycle", int'(pwm_oe), 0);
        @(negedge clk);
        chk(brk_flags == 3'b100, "R11 internal flag", int'(brk_flags), 4);
        wr(2'd1, 12'h1);
        sys_flt = '0;
        @(negedge clk);
        chk(pwm_oe == 1'b0, "R9 write ignored during break", int'(pwm_oe), 0);
        wr(2'd1, 12'h1);
        chk(pwm_oe == 1'b1, "R9 write accepted after release", int'(pwm_oe), 1);
        wr(2'd3, 12'h4);

        // R8 software break on disabled channel B
        wr(2'd0, 12'h000);
        @(negedge clk);
        wr(2'd2, 12'h2);
        chk(pwm_oe == 1'b0, "R8 software break", int'(pwm_oe), 0);
        @(negedge clk);
        chk(brk_flags == 3'b010, "R8 software flag B", int'(brk_flags), 2);
        wr(2'd3, 12'h2);

        // R6 directed threshold boundaries
        run_case(0, 2, 1'b1, 0, 3);
        run_case(0, 2, 1'b1, 0, 4);
        run_case(1, 15, 1'b1, 2, 29);
        run_case(1, 15, 1'b1, 0, 30);
        run_case(1, 0, 1'b0, 0, 1);

        // R4 R6 random mix
        for (int i = 0; i < 40; i++) begin
            int ch, n, src, len;
            bit pol;
            ch  = int'($urandom_range(1, 0));
            n   = int'($urandom_range(3, 0));
            pol = 1'($urandom_range(1, 0));
            src = int'($urandom_range(3, 0));
            len = int'($urandom_range(8, 1));
            run_case(ch, n, pol, src, len);
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule